// File: doc/BRIEF.md
# Keyed-Command Watchdog Timer

This block is a watchdog for a small processor with an 8-bit data path and a 16-bit I/O address. It counts clock cycles toward a timeout chosen from four lengths that grow by powers of four. When the count runs out, it raises an active-high alarm line. Software has to write a fixed key byte to a command location often enough to restart the count. Stopping the watchdog is deliberately awkward. The enable bit in the mode register must be cleared first, and only then does a second key byte written to the command location halt the count.

Only the low byte of the address is decoded. The mode register is readable and writable. The command location can only be written. The block leaves reset enabled with its longest period and counts at once. The alarm line stays high until software clears it. A mode write whose three low bits differ from their expected pattern is still stored, but it also raises a one-cycle misuse pulse. The base period exponent is a parameter (`BASE_LOG2`, default 16).

Top module: `wdg_keyed_top`

## Requirements
- R1: Low address byte 0xF0 selects the mode register, which can be read and written. Low byte 0xF1 selects the command location, which can only be written and reads as 0x00. Address bits 15:8 are ignored. Writes to any other low byte have no effect, and reads of them return 0x00.
- R2: After reset the mode register reads 0xFB and `wdg_alarm` is low. A full count with the longest period has already begun.
- R3: Mode bits 6:5 hold a value s that selects a period of P = 2^(BASE_LOG2+2s) cycles. If no clear arrives, `wdg_alarm` rises on the P-th rising clock edge after the edge that reloaded the count.
- R4: Writing 0x4E to the command location drops `wdg_alarm` on that edge. If mode bit 7 (enable) is 1, the same write also reloads a full count. If the enable bit is 0, the count is not restarted.
- R5: Writing 0xB1 to the command location halts the count only while the enable bit is 0. While the enable bit is 1, this write is ignored and the count runs on.
- R6: A mode write that changes the enable bit from 0 to 1 acts as a clear. It restarts the count using the period written in that same access.
- R7: A mode write that clears the enable bit does not stop a count that is already running.
- R8: A command byte other than 0x4E or 0xB1 has no effect on the count or on `wdg_alarm`.
- R9: Once raised, `wdg_alarm` stays high until the next clear.
- R10: A mode write whose bits 2:0 are not 011 is stored as written. It also drives `wdg_misuse` high for exactly the cycle after the write. A write with bits 2:0 equal to 011 leaves `wdg_misuse` low.
- R11: If a clear and an expiry fall on the same edge, the clear wins and `wdg_alarm` stays low. A change to the period field while the enable bit stays set takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; one count step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address; only bits 7:0 are decoded |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0x00 when not selected |
| wdg_alarm | output | 1 | Timeout alarm, high until cleared |
| wdg_misuse | output | 1 | One-cycle pulse after a mode write with bad reserved bits |

## Verification
The hardest case to reach is a clear key that lands on exactly the edge where the count would expire. Random traffic almost never hits that single cycle. The bench therefore reloads a short period, waits exactly P-1 cycles, and then writes the key. A second hard case is a running count with the enable bit at 0, which is the only state in which the stop key works. Directed steps reach it by raising the enable bit, lowering it again, and then sending the stop key. After that, constrained random traffic from a fixed seed mixes mode writes, keys, stray bytes and idle gaps. A cycle model in the bench predicts the alarm and misuse lines on every cycle.

// File: rtl/wdg_pkg.sv
// Package wdg_pkg
// Shared constants and the mode register layout for the keyed watchdog.
// Assumes an 8-bit data path and a 16-bit I/O address.
package wdg_pkg;
    localparam logic [7:0] ADDR_MODE   = 8'hF0;
    localparam logic [7:0] ADDR_CMD    = 8'hF1;
    localparam logic [7:0] KEY_CLEAR   = 8'h4E;
    localparam logic [7:0] KEY_STOP    = 8'hB1;
    localparam logic [7:0] MODE_RESET  = 8'hFB;
    localparam logic [2:0] RSVD_EXPECT = 3'b011;
    localparam int         SEL_W       = 2;
    localparam int         SEL_N       = 1 << SEL_W;

    typedef struct packed {
        logic             en;     // bit 7: watchdog enable
        logic [SEL_W-1:0] sel;    // bits 6:5: period select
        logic [1:0]       spare;  // bits 4:3: stored, no function
        logic [2:0]       rsvd;   // bits 2:0: expected 011
    } mode_t;
endpackage

// File: rtl/wdg_bus_decode.sv
// Module wdg_bus_decode
// Decodes the low address byte into mode and command strobes and
// recognises the two key bytes. Purely combinational.
// Assumes at most one access (read or write) per cycle.
module wdg_bus_decode
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic        mode_wr,
    output logic        mode_rd,
    output logic        clear_key,
    output logic        stop_key
);
    logic [7:0] low_addr;
    logic       unused_hi_addr;
    logic       cmd_wr;

    // Only the low byte of the address takes part in decoding.
    assign low_addr       = io_addr[7:0];
    assign unused_hi_addr = ^io_addr[15:8];

    // Turn the access into per-register strobes and key detects.
    always_comb begin
        mode_wr   = io_wr && (low_addr == ADDR_MODE);
        mode_rd   = io_rd && (low_addr == ADDR_MODE);
        cmd_wr    = io_wr && (low_addr == ADDR_CMD);
        clear_key = cmd_wr && (io_wdata == KEY_CLEAR);
        stop_key  = cmd_wr && (io_wdata == KEY_STOP);
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_wr, clear_key, stop_key})); // R1
endmodule

// File: rtl/wdg_mode_reg.sv
// Module wdg_mode_reg
// Holds the mode register. Detects a 0->1 change of the enable bit and
// reports the period to use on a reload. Raises a misuse pulse when a
// write carries unexpected reserved bits; the value is stored anyway.
// Assumes a synchronous active-low reset.
module wdg_mode_reg
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [7:0]       wdata,
    output mode_t            mode,
    output logic             en_rise,
    output logic [SEL_W-1:0] reload_sel,
    output logic             misuse
);
    mode_t mode_q;
    mode_t wr_val;

    assign wr_val = mode_t'(wdata);
    assign mode   = mode_q;

    // Store every mode write as written; reset loads the power-on value.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= mode_t'(MODE_RESET);
        else if (mode_wr) mode_q <= wr_val;
    end

    // Flag a mode write whose reserved field is not the expected pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) misuse <= 1'b0;
        else        misuse <= mode_wr && (wr_val.rsvd != RSVD_EXPECT);
    end

    // An enabling write reloads with the period it carries itself.
    always_comb begin
        en_rise    = mode_wr && !mode_q.en && wr_val.en;
        reload_sel = mode_wr ? wr_val.sel : mode_q.sel;
    end

    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && (wdata[2:0] != RSVD_EXPECT)) |=> misuse); // R10
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> !misuse); // R10
    AST_MODE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_q == $past(wr_val))); // R1
endmodule

// File: rtl/wdg_count.sv
// Module wdg_count
// Down-counter and alarm flop. A reload loads period-1 and starts the
// count. At zero the alarm rises and the count halts. A clear drops the
// alarm and blocks an expiry on the same edge. The stop request halts the
// count only while the enable bit is low.
// Assumes the caller asserts reload only together with clear.
module wdg_count
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 16,
    parameter int CNT_W     = BASE_LOG2 + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [SEL_W-1:0] sel,
    input  logic             clear,
    input  logic             stop_req,
    input  logic             en,
    output logic             alarm
);
    localparam logic [SEL_W-1:0] RST_SEL = MODE_RESET[6:5];

    logic [CNT_W-1:0] reload_tbl [SEL_N];
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             alarm_q;
    logic             stop_ok;
    logic             at_zero;
    logic             expire;

    // One reload value per period select: 2^(BASE+2s) - 1.
    for (genvar g = 0; g < SEL_N; g++) begin : g_period
        assign reload_tbl[g] = CNT_W'((64'd1 << (BASE_LOG2 + 2 * g)) - 64'd1);
    end

    // Decide whether this edge stops the count or ends it by expiry.
    always_comb begin
        stop_ok = stop_req && !en;
        at_zero = (cnt_q == '0);
        expire  = run_q && at_zero && !clear && !stop_ok;
    end

    // Count state: stop beats reload, reload beats counting down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= reload_tbl[RST_SEL];
            run_q <= 1'b1;
        end else if (stop_ok) begin
            run_q <= 1'b0;
        end else if (reload) begin
            cnt_q <= reload_tbl[sel];
            run_q <= 1'b1;
        end else if (run_q) begin
            if (!at_zero)    cnt_q <= cnt_q - 1'b1;
            else if (expire) run_q <= 1'b0;
        end
    end

    // Alarm flop: set on expiry, cleared only by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      alarm_q <= 1'b0;
        else if (clear)  alarm_q <= 1'b0;
        else if (expire) alarm_q <= 1'b1;
    end

    assign alarm = alarm_q;

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && !clear) |=> alarm_q); // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !alarm_q); // R4
    AST_RELOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (run_q && cnt_q != '0)); // R4
    AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> ($past(cnt_q) == '0 && $past(run_q))); // R3
    AST_STOP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && en && run_q && !at_zero) |=> run_q); // R5
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !en) |=> !run_q); // R5
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !reload) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/wdg_keyed_top.sv
// Module wdg_keyed_top
// Keyed-command watchdog on an 8-bit I/O bus: bus decode, mode register
// and down-counter. A clear comes from the clear key or from a write that
// turns the enable bit on; the count reloads only while enabled.
// Assumes one bus access per cycle and a synchronous active-low reset.
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        wdg_alarm,
    output logic        wdg_misuse
);
    localparam int CNT_W = BASE_LOG2 + 7;

    logic             mode_wr;
    logic             mode_rd;
    logic             clear_key;
    logic             stop_key;
    mode_t            mode;
    logic             en_rise;
    logic [SEL_W-1:0] reload_sel;
    logic             do_clear;
    logic             do_reload;

    wdg_bus_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .mode_wr   (mode_wr),
        .mode_rd   (mode_rd),
        .clear_key (clear_key),
        .stop_key  (stop_key)
    );

    wdg_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .wdata      (io_wdata),
        .mode       (mode),
        .en_rise    (en_rise),
        .reload_sel (reload_sel),
        .misuse     (wdg_misuse)
    );

    // Combine the clear sources; the count reloads only when enabled.
    always_comb begin
        do_clear  = en_rise || clear_key;
        do_reload = en_rise || (clear_key && mode.en);
    end

    wdg_count #(
        .BASE_LOG2 (BASE_LOG2),
        .CNT_W     (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (do_reload),
        .sel      (reload_sel),
        .clear    (do_clear),
        .stop_req (stop_key),
        .en       (mode.en),
        .alarm    (wdg_alarm)
    );

    // Read path: only the mode register is readable.
    always_comb io_rdata = mode_rd ? 8'(mode) : 8'h00;

    AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == 8'h00)); // R1
endmodule

// File: tb/wdg_keyed_top_bench.sv
module wdg_keyed_top_bench;
    localparam int B = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        wdg_alarm;
    logic        wdg_misuse;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    wdg_keyed_top #(.BASE_LOG2(B)) u_wdg_keyed_top (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .wdg_alarm(wdg_alarm), .wdg_misuse(wdg_misuse)
    );

    function automatic int per(input logic [1:0] s);
        return 1 << (B + 2 * s);
    endfunction

    // Reference cycle model built from the requirements.
    logic [7:0] m_mode;
    int         m_cnt;
    bit         m_run, m_out, m_mis;

    always @(posedge clk) begin
        logic [7:0] nm;
        bit clr, stp, mw, cw;
        if (!rst_n) begin
            m_mode <= 8'hFB; m_cnt <= per(2'd3) - 1; m_run <= 1'b1;
            m_out <= 1'b0; m_mis <= 1'b0;
        end else begin
            nm  = m_mode; clr = 1'b0; stp = 1'b0;
            mw  = io_wr && io_addr[7:0] == 8'hF0;
            cw  = io_wr && io_addr[7:0] == 8'hF1;
            m_mis <= mw && (io_wdata[2:0] != 3'b011);
            if (mw) begin
                nm = io_wdata;
                if (!m_mode[7] && io_wdata[7]) clr = 1'b1;
            end
            if (cw && io_wdata == 8'h4E) clr = 1'b1;
            if (cw && io_wdata == 8'hB1 && !m_mode[7]) stp = 1'b1;
            m_mode <= nm;
            if (stp) m_run <= 1'b0;
            else if (clr && nm[7]) begin
                m_cnt <= per(nm[6:5]) - 1; m_run <= 1'b1;
            end else if (m_run) begin
                if (m_cnt == 0) begin
                    if (!clr) begin m_run <= 1'b0; m_out <= 1'b1; end
                end else m_cnt <= m_cnt - 1;
            end
            if (clr) m_out <= 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Every cycle: alarm and misuse lines against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R9 alarm vs model", int'(wdg_alarm), int'(m_out));
            chk("R10 misuse vs model", int'(wdg_misuse), int'(m_mis));
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20211));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R2 reset state, R1 decode of reads
        rd(16'h00F0, d); chk("R2 mode after reset", d, 8'hFB);
        chk("R2 alarm after reset", wdg_alarm, 0);
        rd(16'hA5F0, d); chk("R1 upper byte ignored on read", d, 8'hFB);
        rd(16'h00F1, d); chk("R1 command reads zero", d, 8'h00);

        // R6 enable rise restarts with new period; R3 exact timing
        wr(16'h00F0, 8'h03);
        wr(16'h00F1, 8'hB1);
        wr(16'h33F0, 8'h83);
        wait_neg(per(0) - 1); chk("R3 no alarm before P edges", wdg_alarm, 0);
        wait_neg(1);          chk("R6 alarm at P after enabling write", wdg_alarm, 1);

        // R9 sticky, R8 stray command, R4 clear
        wait_neg(40);          chk("R9 alarm stays high", wdg_alarm, 1);
        wr(16'h00F1, 8'h55);   chk("R8 stray command ignored", wdg_alarm, 1);
        wr(16'h00F1, 8'h4E);   chk("R4 clear drops alarm", wdg_alarm, 0);

        // R11 clear on the expiry edge wins
        wait_neg(per(0) - 1);
        wr(16'h00F1, 8'h4E);   chk("R11 clear beats expiry", wdg_alarm, 0);
        wait_neg(per(0) - 1);  chk("R11 restarted count still low", wdg_alarm, 0);
        wait_neg(1);           chk("R11 restarted count expires", wdg_alarm, 1);

        // R11 period change waits for next reload
        wr(16'h00F1, 8'h4E);
        wr(16'h00F0, 8'hA3);
        wait_neg(per(0) - 2);  chk("R11 old period still low", wdg_alarm, 0);
        wait_neg(1);           chk("R11 old period applies", wdg_alarm, 1);
        wr(16'h00F1, 8'h4E);
        wait_neg(per(1) - 1);  chk("R3 period s=1 low", wdg_alarm, 0);
        wait_neg(1);           chk("R3 period s=1 expires", wdg_alarm, 1);

        // R5 stop key ignored while enabled
        wr(16'h00F1, 8'h4E);
        wr(16'h00F1, 8'hB1);
        wait_neg(per(1) - 2);  chk("R5 locked stop, still low", wdg_alarm, 0);
        wait_neg(1);           chk("R5 locked stop, count ran", wdg_alarm, 1);

        // R7 clearing enable alone keeps counting
        wr(16'h00F1, 8'h4E);
        wr(16'h00F0, 8'h23);
        wait_neg(per(1) - 2);  chk("R7 still low", wdg_alarm, 0);
        wait_neg(1);           chk("R7 count kept running", wdg_alarm, 1);

        // R5 two-step stop; R4 clear while disabled does not restart
        wr(16'h00F0, 8'hA3);   chk("R6 enabling write clears", wdg_alarm, 0);
        wr(16'h00F0, 8'h23);
        wr(16'h00F1, 8'hB1);
        wait_neg(3 * per(1));  chk("R5 stopped count never expires", wdg_alarm, 0);
        wr(16'h00F1, 8'h4E);
        wait_neg(3 * per(1));  chk("R4 disabled clear no restart", wdg_alarm, 0);

        // R10 reserved bits stored and flagged
        wr(16'h00F0, 8'h05);   chk("R10 misuse pulse", wdg_misuse, 1);
        rd(16'h00F0, d);       chk("R10 value stored", d, 8'h05);
        chk("R10 pulse lasts one cycle", wdg_misuse, 0);
        wr(16'h00F0, 8'h1B);   chk("R10 good pattern no pulse", wdg_misuse, 0);

        // R1 write decode
        wr(16'h00F0, 8'h83);
        wait_neg(per(0) + 4);  chk("R1 expiry before decode test", wdg_alarm, 1);
        wr(16'h00F2, 8'h4E);   chk("R1 other address ignored", wdg_alarm, 1);
        wr(16'hFFF1, 8'h4E);   chk("R1 upper byte ignored on write", wdg_alarm, 0);

        // Constrained random traffic against the model
        for (int i = 0; i < 2500; i++) begin
            int op;
            logic [7:0] v;
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: wait_neg($urandom_range(0, 30));
                3: begin
                    v = {1'($urandom_range(0, 1)), 2'($urandom_range(0, 1)),
                         2'($urandom_range(0, 3)), 3'b011};
                    if ($urandom_range(0, 3) == 0) v[2:0] = 3'($urandom_range(0, 7));
                    if ($urandom_range(0, 7) == 0) v[6:5] = 2'd2;
                    wr({8'($urandom_range(0, 255)), 8'hF0}, v);
                end
                4, 5: wr({8'($urandom_range(0, 255)), 8'hF1}, 8'h4E);
                6: wr(16'h00F1, 8'hB1);
                7: wr(16'h00F1, 8'($urandom_range(0, 255)));
                8: begin
                    v = m_mode;
                    rd({8'($urandom_range(0, 255)), 8'hF0}, d);
                    chk("R1 random read vs model", d, v);
                end
                default: begin
                    v = 8'($urandom_range(0, 255));
                    if (v == 8'hF0 || v == 8'hF1) v = 8'h10;
                    wr({8'h00, v}, 8'($urandom_range(0, 255)));
                end
            endcase
        end

        // R2 reset in the middle of activity
        rst_n = 1'b0;
        wait_neg(2);
        rst_n = 1'b1;
        rd(16'h00F0, d);       chk("R2 mode after second reset", d, 8'hFB);
        chk("R2 alarm after second reset", wdg_alarm, 0);
        wait_neg(2);
        finish_run();
    end
endmodule